// File: doc/BRIEF.md
# Serial Word Parity Checker

This block watches a one-bit serial stream and checks every word for even parity. A bit is accepted on each rising clock edge where the valid strobe is high. The block keeps a count of the bits accepted so far in the current word and a running XOR of those bits.

Every word is `WORD_BITS` bits long, and its last bit is the transmitted parity bit. When that last bit is accepted, the block compares it with the accumulated XOR. In the next cycle it raises a one-cycle completion pulse, together with an error flag if the two disagree. The count and the XOR are then cleared without any outside command, so the following word may start on the very next valid cycle.

Framing is the job of the surrounding logic. This block only assumes that the first accepted bit after reset, or after a completed word, is the first bit of a word.

Top module: `par_word_chk`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `word_done` = 0 and `par_err` = 0, and the bit count and running parity are cleared.
- R2: A cycle with `in_valid` low changes neither the bit count nor the running parity, and never produces a `word_done` pulse in the following cycle.
- R3: `word_done` is high for exactly the one cycle after the edge on which the `WORD_BITS`-th valid bit of a word was accepted, and is low in every other cycle.
- R4: In the `word_done` cycle, `par_err` is 1 exactly when the XOR of all `WORD_BITS` accepted bits, parity bit included, is 1 (even parity).
- R5: `par_err` is 0 in every cycle where `word_done` is 0.
- R6: After a check the block is ready for a new word at once, so words sent back to back with no idle cycle are each checked on their own.
- R7: A reset that arrives part way through a word discards the bits already accepted, and the next accepted bit is treated as bit 0 of a new word.
- R8: `word_done` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | High when `in_bit` holds a bit to be taken |
| in_bit | input | 1 | Serial data bit; the last bit of each word is its parity bit |
| word_done | output | 1 | One-cycle pulse after the last bit of a word is taken |
| par_err | output | 1 | Parity mismatch flag, meaningful only while `word_done` is high |

## Verification
Both outputs are registered, so each result appears exactly one cycle after the rising edge that accepted the final bit of a word. A reset shows its effect one cycle after the edge on which it was sampled. The bench drives its inputs on the falling edge and reads the outputs one nanosecond after the following rising edge. At that point it compares them with a bench model that has just taken the same bit, so every result is checked in the cycle it is due. Gaps with the strobe low, back-to-back words, corrupted parity bits and a reset in the middle of a word are all driven through that same per-cycle comparison.

// File: rtl/par_chk_pkg.sv
package par_chk_pkg;
  typedef enum logic [1:0] {
    PC_IDLE  = 2'd0,
    PC_ACC   = 2'd1,
    PC_CHECK = 2'd2
  } pc_state_e;
endpackage

// File: rtl/par_bit_counter.sv
module par_bit_counter #(
  parameter int WORD_BITS = 9,
  parameter int CNT_W     = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             wrap,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || (take && wrap)) begin
      count <= '0;
    end else if (take) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/par_accum.sv
module par_accum (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic wrap,
  input  logic bit_in,
  output logic par_q
);
  always_ff @(posedge clk) begin
    if (rst || (take && wrap)) begin
      par_q <= 1'b0;
    end else if (take) begin
      par_q <= par_q ^ bit_in;
    end
  end
endmodule

// File: rtl/par_fsm.sv
module par_fsm
  import par_chk_pkg::*;
#(
  parameter int WORD_BITS = 9,
  parameter int CNT_W     = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [CNT_W-1:0] count,
  output logic             chk_fire
);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(WORD_BITS - 2);

  pc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PC_IDLE: begin
        if (take) begin
          if (WORD_BITS == 2) state_d = PC_CHECK;
          else                state_d = PC_ACC;
        end
      end
      PC_ACC: begin
        if (take && (count == LAST_DATA)) state_d = PC_CHECK;
      end
      PC_CHECK: begin
        if (take) state_d = PC_IDLE;
      end
      default: state_d = PC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PC_IDLE;
    else     state_q <= state_d;
  end

  assign chk_fire = take && (state_q == PC_CHECK);
endmodule

// File: rtl/par_word_chk.sv
module par_word_chk #(
  parameter int WORD_BITS = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic word_done,
  output logic par_err
);
  localparam int CNT_W = (WORD_BITS > 2) ? $clog2(WORD_BITS) : 1;

  logic [CNT_W-1:0] count;
  logic             par_q;
  logic             chk_fire;

  par_bit_counter #(.WORD_BITS(WORD_BITS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .take(in_valid), .wrap(chk_fire), .count(count)
  );

  par_accum u_acc (
    .clk(clk), .rst(rst), .take(in_valid), .wrap(chk_fire),
    .bit_in(in_bit), .par_q(par_q)
  );

  par_fsm #(.WORD_BITS(WORD_BITS), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .take(in_valid), .count(count), .chk_fire(chk_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_done <= 1'b0;
      par_err   <= 1'b0;
    end else begin
      word_done <= chk_fire;
      par_err   <= chk_fire && (par_q ^ in_bit);
    end
  end
endmodule

// File: rtl/par_word_chk_sva.sv
module par_word_chk_sva (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic word_done,
  input logic par_err
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!word_done && !par_err));

  // R5
  err_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    par_err |-> word_done);

  // R8
  no_double_done_chk: assert property (@(posedge clk) disable iff (rst)
    word_done |=> !word_done);

  // R2
  gap_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !word_done);

  // R3
  done_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(word_done) |-> $past(in_valid));
endmodule

bind par_word_chk par_word_chk_sva u_sva (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .word_done(word_done), .par_err(par_err)
);

// File: tb/sim_par_word_chk.sv
module sim_par_word_chk;
  localparam int WB = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic word_done, par_err;

  int n_vec = 0;
  int n_bad = 0;
  int m_cnt = 0;
  logic m_par = 1'b0;
  logic e_done = 1'b0;
  logic e_err = 1'b0;

  always #2 clk = ~clk;

  par_word_chk #(.WORD_BITS(WB)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .word_done(word_done), .par_err(par_err)
  );

  function automatic logic even_par(input logic [WB-2:0] d);
    return ^d;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic b, input string tag);
    in_valid = v;
    in_bit   = b;
    @(posedge clk);
    e_done = 1'b0;
    e_err  = 1'b0;
    if (v) begin
      if (m_cnt == WB - 1) begin
        e_done = 1'b1;
        e_err  = m_par ^ b;
        m_cnt  = 0;
        m_par  = 1'b0;
      end else begin
        m_cnt++;
        m_par = m_par ^ b;
      end
    end
    #1;
    chk(tag, "word_done", word_done, e_done);
    chk((tag == "R3") ? "R4" : tag, "par_err", par_err, e_err);
    @(negedge clk);
  endtask

  task automatic do_reset(input string tag);
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    m_cnt = 0;
    m_par = 1'b0;
    #1;
    chk(tag, "word_done", word_done, 1'b0);
    chk(tag, "par_err", par_err, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_word(input logic [WB-2:0] d, input logic corrupt, input string tag);
    for (int i = 0; i < WB - 1; i++) step(1'b1, d[i], tag);
    step(1'b1, even_par(d) ^ corrupt, tag);
  endtask

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd7);
    @(negedge clk);
    do_reset("R1");

    // R4: correct and corrupted parity
    send_word(8'hA5, 1'b0, "R4");
    send_word(8'hA5, 1'b1, "R4");
    send_word(8'h01, 1'b0, "R4");
    send_word(8'hFE, 1'b1, "R4");

    // R6: back-to-back words, no idle cycle
    send_word(8'h3C, 1'b0, "R6");
    send_word(8'h7F, 1'b1, "R6");
    send_word(8'h00, 1'b0, "R6");

    // R2: gaps inside a word
    for (int i = 0; i < WB; i++) begin
      step(1'b1, 1'(i % 3 == 0), "R2");
      step(1'b0, 1'b1, "R2");
      step(1'b0, 1'b0, "R2");
    end

    // R7: reset part way through a word
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R7");
    do_reset("R7");
    send_word(8'h81, 1'b1, "R7");

    // R3 / R5 / R8: random traffic
    for (int i = 0; i < 3000; i++) begin
      logic v, b;
      v = ($urandom % 4) != 0;
      b = 1'($urandom % 2);
      step(v, b, "R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule